// File: doc/BRIEF.md
# Timed Power Switch Controller

This block is the decision logic of an automatic shut-off mains switch. Two active-low request pins, one to switch the load on and one to switch it off, are sampled into the clock domain. Each pin only counts once it has stayed low across several line-cycle strobes. A qualified switch-on request sets the power-enable output and starts a timeout. The timeout is measured in ticks from an external timing oscillator, and when it runs out the output drops again. A qualified switch-off request drops the output at once.

The line strobe and the oscillator tick each arrive as one-clock pulses from circuitry outside this block. The block does not handle phase-angle firing or line tracking. The two request pins lock each other out: a request is refused while the opposite pin is being held low. A fresh switch-on request that arrives while the load is already on restarts the timeout from zero. There is no data stream, so every pin is a plain control or status level.

Top module: `timed_switch_ctrl`

## Requirements
- R1: After reset, `power_en` is 0 (off state), and it stays 0 until a switch-on request qualifies.
- R2: A request pin counts as qualified on the third `line_tick` pulse seen while its synchronised level is low. The pin level passes through two flops before counting starts. A qualified switch-on request sets `power_en` at the next clock edge. Two such pulses are not enough.
- R3: The qualification count for a pin returns to zero whenever that pin goes back high, so separate low periods never add up.
- R4: A request acts only once per low period. Holding the switch-on pin low does not keep restarting the timeout, and the output still turns off when the timeout ends.
- R5: While on, the controller counts `osc_tick` pulses. `power_en` clears at the clock edge of the TIMEOUT_TICKS-th tick (255 by default) and stays 1 after one tick fewer.
- R6: `osc_tick` pulses that arrive while the output is off are not counted. Each on period starts its timeout from zero.
- R7: A new qualified switch-on request while the output is on restarts the timeout from zero.
- R8: A qualified switch-off request clears `power_en`.
- R9: A switch-on request has no effect while the switch-off pin is held low.
- R10: A switch-off request has no effect while the switch-on pin is held low.
- R11: If no `osc_tick` pulses arrive, the output stays on until a switch-off request qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; when low the block goes to the off state |
| line_tick | input | 1 | One-clock pulse per line cycle |
| osc_tick | input | 1 | One-clock pulse per timing-oscillator period |
| on_req_n | input | 1 | Switch-on request, active low, asynchronous |
| off_req_n | input | 1 | Switch-off request, active low, asynchronous |
| power_en | output | 1 | High while the controller is in the timed-on state |

## Verification
The assertions check on every cycle that the following hold:
- the timeout count stays in range and is held at zero while the output is off;
- a qualification pulse never repeats on the next cycle;
- each accepted request and each expiry moves the state as required;
- the output never rises while the switch-off pin is held low, and never falls because of a switch-off request while the switch-on pin is held low.

Other behaviours show only over long scenarios, which the bench drives against its reference model: the exact tick on which the timeout expires, a restart part-way through a timeout, no restart while the switch-on pin is held low, and qualification counts that are abandoned when a pin goes back high.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  typedef enum logic {
    MODE_OFF = 1'b0,
    MODE_ON  = 1'b1
  } mode_e;
endpackage

// File: rtl/tsw_req_qual.sv
module tsw_req_qual #(
  parameter int QUAL_CYCLES = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  input  logic line_tick,
  output logic held_low,
  output logic fire
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);
  localparam logic [CW-1:0] FULL = CW'(QUAL_CYCLES);

  logic [SYNC_STAGES-1:0] chain;
  logic [CW-1:0]          cnt;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= req_n;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[SYNC_STAGES-2:0], req_n};
    end
  endgenerate

  assign held_low = ~chain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (!held_low)              cnt <= '0;
    else if (line_tick && cnt != FULL) cnt <= cnt + 1'b1;
  end

  assign fire = held_low && line_tick && (cnt == LAST);

  // R4
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

  // R3
  release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !held_low |=> (cnt == '0));
endmodule

// File: rtl/tsw_timeout.sv
module tsw_timeout #(
  parameter int TIMEOUT_TICKS = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic osc_tick,
  output logic expire
);
  localparam int TW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_TICKS - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || !run)  cnt <= '0;
    else if (osc_tick)         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign expire = run && osc_tick && !restart && (cnt == LAST);

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R6
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

// File: rtl/tsw_mode_fsm.sv
module tsw_mode_fsm
  import tsw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  on_go,
  input  logic  off_go,
  input  logic  expire,
  output mode_e mode
);
  mode_e mode_nx;

  always_comb begin
    mode_nx = mode;
    if (off_go)      mode_nx = MODE_OFF;
    else if (on_go)  mode_nx = MODE_ON;
    else if (expire) mode_nx = MODE_OFF;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode <= MODE_OFF;
    else        mode <= mode_nx;

  // R8
  off_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_go |=> (mode == MODE_OFF));

  // R2
  on_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_go && !off_go) |=> (mode == MODE_ON));

  // R5
  expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !on_go && !off_go) |=> (mode == MODE_OFF));
endmodule

// File: rtl/timed_switch_ctrl.sv
module timed_switch_ctrl
  import tsw_pkg::*;
#(
  parameter int QUAL_CYCLES   = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int TIMEOUT_TICKS = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_tick,
  input  logic osc_tick,
  input  logic on_req_n,
  input  logic off_req_n,
  output logic power_en
);
  logic  on_low, on_fire, off_low, off_fire;
  logic  on_go, off_go, tmr_expire;
  mode_e mode;

  tsw_req_qual #(.QUAL_CYCLES(QUAL_CYCLES), .SYNC_STAGES(SYNC_STAGES)) on_qual_i (
    .clk(clk), .rst_n(rst_n), .req_n(on_req_n), .line_tick(line_tick),
    .held_low(on_low), .fire(on_fire));

  tsw_req_qual #(.QUAL_CYCLES(QUAL_CYCLES), .SYNC_STAGES(SYNC_STAGES)) off_qual_i (
    .clk(clk), .rst_n(rst_n), .req_n(off_req_n), .line_tick(line_tick),
    .held_low(off_low), .fire(off_fire));

  // mutual lockout between the two request pins
  assign on_go  = on_fire && !off_low;
  assign off_go = off_fire && !on_low;

  tsw_timeout #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(mode == MODE_ON), .restart(on_go),
    .osc_tick(osc_tick), .expire(tmr_expire));

  tsw_mode_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .on_go(on_go), .off_go(off_go),
    .expire(tmr_expire), .mode(mode));

  assign power_en = (mode == MODE_ON);

  // R9
  on_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_en) |-> !$past(off_low));

  // R10
  off_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(power_en) && !$past(tmr_expire)) |-> !$past(on_low));

  // R11
  hold_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (power_en && !osc_tick && !off_go) |=> power_en);
endmodule

// File: tb/timed_switch_ctrl_tb.sv
module timed_switch_ctrl_tb_top;
  localparam int Q = 3;
  localparam int T = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_tick = 1'b0;
  logic osc_tick = 1'b0;
  logic on_req_n = 1'b1;
  logic off_req_n = 1'b1;
  logic power_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  timed_switch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .osc_tick(osc_tick),
    .on_req_n(on_req_n), .off_req_n(off_req_n), .power_en(power_en));

  // behavioural reference: pin histories, qualification counts, mode, timer
  bit on_hist[$];
  bit off_hist[$];
  int m_qon = 0, m_qoff = 0, m_tc = 0;
  bit m_on = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      on_hist = {1'b1, 1'b1};
      off_hist = {1'b1, 1'b1};
      m_qon = 0; m_qoff = 0; m_tc = 0; m_on = 1'b0;
    end else begin
      bit on_lvl, off_lvl, on_q, off_q, on_ok, off_ok;
      on_lvl  = !on_hist[0];
      off_lvl = !off_hist[0];
      on_q  = on_lvl  && line_tick && (m_qon  == Q - 1);
      off_q = off_lvl && line_tick && (m_qoff == Q - 1);
      on_ok  = on_q  && !off_lvl;
      off_ok = off_q && !on_lvl;
      if (off_ok) begin
        m_on = 1'b0; m_tc = 0;
      end else if (on_ok) begin
        m_on = 1'b1; m_tc = 0;
      end else if (m_on && osc_tick) begin
        m_tc++;
        if (m_tc == T) begin m_on = 1'b0; m_tc = 0; end
      end
      if (!on_lvl) m_qon = 0;
      else if (line_tick && m_qon < Q) m_qon++;
      if (!off_lvl) m_qoff = 0;
      else if (line_tick && m_qoff < Q) m_qoff++;
      void'(on_hist.pop_front());
      void'(off_hist.pop_front());
      on_hist.push_back(on_req_n);
      off_hist.push_back(off_req_n);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (power_en !== m_on) begin
        errors++;
        $display("FAIL model compare (R2,R5,R7,R8) cycle %0d actual %0b expected %0b",
                 cyc, power_en, m_on);
      end
    end
  end

  task automatic check(input bit exp, input string tag);
    checks++;
    if (power_en !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, power_en, exp);
    end
  endtask

  task automatic line_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) line_tick = 1'b1;
      @(negedge clk) line_tick = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic osc_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) osc_tick = 1'b1;
      @(negedge clk) osc_tick = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic set_on(input bit v);
    @(negedge clk) on_req_n = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_off(input bit v);
    @(negedge clk) off_req_n = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic press_on();
    set_on(1'b0); line_pulses(Q); set_on(1'b1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired (R1) actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(1'b0, "R1 during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1'b0, "R1 after reset");

    // R2: two pulses not enough, third qualifies
    set_on(1'b0);
    line_pulses(Q - 1);
    check(1'b0, "R2 two pulses");
    line_pulses(1);
    check(1'b1, "R2 third pulse");
    set_on(1'b1);

    // R5: expiry on the last tick
    osc_pulses(T - 1);
    check(1'b1, "R5 one tick short");
    osc_pulses(1);
    check(1'b0, "R5 expired");

    // R6: ticks while off ignored
    osc_pulses(10);
    press_on();
    osc_pulses(T - 1);
    check(1'b1, "R6 idle ticks ignored");
    osc_pulses(1);
    check(1'b0, "R6 full timeout");

    // R3: interrupted low periods do not add up
    set_on(1'b0); line_pulses(Q - 1); set_on(1'b1);
    set_on(1'b0); line_pulses(Q - 1);
    check(1'b0, "R3 count cleared on release");
    line_pulses(1);
    check(1'b1, "R3 fresh qualification");
    set_on(1'b1);

    // R7: restart mid timeout
    osc_pulses(200);
    press_on();
    osc_pulses(200);
    check(1'b1, "R7 restarted timeout");
    osc_pulses(T - 200);
    check(1'b0, "R7 expiry after restart");

    // R4: held low does not keep restarting
    set_on(1'b0);
    line_pulses(Q);
    for (int i = 0; i < T; i++) begin
      osc_pulses(1);
      if (i % 50 == 0) line_pulses(1);
    end
    check(1'b0, "R4 held request acts once");
    set_on(1'b1);

    // R8: switch-off request
    press_on();
    check(1'b1, "R8 on before off");
    set_off(1'b0); line_pulses(Q); set_off(1'b1);
    check(1'b0, "R8 off request");

    // R9: on refused while off held
    set_off(1'b0);
    set_on(1'b0); line_pulses(Q + 2);
    check(1'b0, "R9 on locked out");
    set_on(1'b1);
    set_off(1'b1);

    // R10: off refused while on held
    press_on();
    set_on(1'b0);
    set_off(1'b0); line_pulses(Q + 2);
    check(1'b1, "R10 off locked out");
    set_off(1'b1);
    set_on(1'b1);

    // R11: no oscillator, stays on
    repeat (2000) @(negedge clk);
    check(1'b1, "R11 no ticks stays on");
    set_off(1'b0); line_pulses(Q); set_off(1'b1);
    check(1'b0, "R11 off ends hold");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule